// File: doc/BRIEF.md
# Two-Channel Serial ADC Device Emulator

This block stands in for a two-channel, 8-bit serial ADC on the device side of a four-wire serial link. A host controller under test drives chip select, serial clock and command data. The emulator answers on its data output exactly as the converter would, edge for edge. It draws its conversion values from two sample ports instead of from analog inputs, so a host controller can be checked against known data without a real converter.

All link inputs are brought into a fast system clock domain. There they form an internal serial clock that is forced high while chip select is high. A fall of chip select while the serial clock is low therefore counts as the first falling edge of a frame. Each frame lasts sixteen serial clocks. The 8-bit control word shifted in during a frame selects the channel for the following frame, not the current one. When the host keeps chip select low, frames follow one another without a gap. A control word that sets the reserved high-address bit is flagged, and the conversion it governs returns a fixed substitute pattern.

Top module: `adc_serial_emu`

## Requirements
- R1: While chip select is high, `dout_oe` is 0 and `dout` is high-impedance. While chip select is low, `dout_oe` is 1.
- R2: If the serial clock is low when chip select falls, that fall counts as internal falling edge 1. Only 15 further real falling edges complete the frame.
- R3: If the serial clock is high when chip select falls, the first real falling edge after it is internal falling edge 1.
- R4: `dout` changes only after internal falling edges. It is 0 in clocks 1-4 and 13-16 of a frame. In clocks 5-12 it carries the conversion value, MSB first.
- R5: The conversion value is taken from the selected sample port at internal falling edge 4. Later changes on the sample ports do not alter the rest of that frame.
- R6: Rising edges 1-8 of a frame shift in a control word, MSB first. Bit 3 chooses the channel for the next frame: 0 selects `ch0_sample`, 1 selects `ch1_sample`. Bits 7, 6, 5, 2, 1 and 0 have no effect.
- R7: After reset the pending channel is `ch0_sample`.
- R8: If bit 4 of a control word is 1, `addr_err` rises at that frame's eighth rising edge. It stays high until a control word with bit 4 clear completes its eighth rising edge. The next frame's data clocks carry the pattern 8'hA5 in place of a sample.
- R9: With chip select held low, the falling edge after the sixteenth rising edge begins a new frame. Each frame captures its own control word.
- R10: A frame cut short by chip select rising before its eighth rising edge leaves the pending channel and `addr_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select from host, active low |
| sclk | input | 1 | Serial clock from host |
| din | input | 1 | Serial control data from host |
| ch0_sample | input | 8 | Conversion value for the first channel |
| ch1_sample | input | 8 | Conversion value for the second channel |
| dout | output | 1 | Serial result to host, high-impedance when deselected |
| dout_oe | output | 1 | High while `dout` is driven |
| addr_err | output | 1 | Latched control word set the reserved address bit |

## Verification
Frames are run with both serial clock idle levels. A design that ignored the chip-select fall as an edge, or counted it when the clock idled high, would shift the whole result by one clock. The channel pipeline is checked by changing the selection from frame to frame, and a design that applied the address in the same frame returns the wrong channel's value. Frames are also aborted after five rising edges, where an early commit would corrupt the next result. Back-to-back frames under a low chip select catch a counter that fails to wrap. Sample ports changed after the hold edge catch a design that reads them live.

// File: rtl/adc_emu_pkg.sv
// Shared types for the serial ADC emulator.
package adc_emu_pkg;
    // Channel request latched from one control word, applied in the next frame.
    typedef struct packed {
        logic sel;   // 0: first channel, 1: second channel
        logic bad;   // reserved address bit was set
    } chan_req_t;
endpackage

// File: rtl/adc_emu_edges.sv
// Synchronises the serial link into clk and forms the internal serial clock.
// Assumes clk is several times faster than sclk. The internal clock is held
// high while chip select is high, so a chip-select fall with sclk low is seen
// as a falling edge.
module adc_emu_edges #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_s,
    output logic din_s,
    output logic fall_ev,
    output logic rise_ev
);
    logic [SYNC_STAGES-1:0] cs_p, sclk_p, din_p;
    logic gs_now, gs_prev;

    genvar i;
    for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            // First synchroniser stage samples the pins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cs_p[0]   <= 1'b1;
                    sclk_p[0] <= 1'b0;
                    din_p[0]  <= 1'b0;
                end else begin
                    cs_p[0]   <= cs_n;
                    sclk_p[0] <= sclk;
                    din_p[0]  <= din;
                end
            end
        end else begin : g_next
            // Further stages extend the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cs_p[i]   <= 1'b1;
                    sclk_p[i] <= 1'b0;
                    din_p[i]  <= 1'b0;
                end else begin
                    cs_p[i]   <= cs_p[i-1];
                    sclk_p[i] <= sclk_p[i-1];
                    din_p[i]  <= din_p[i-1];
                end
            end
        end
    end

    assign cs_s   = cs_p[SYNC_STAGES-1];
    assign din_s  = din_p[SYNC_STAGES-1];
    assign gs_now = cs_s | sclk_p[SYNC_STAGES-1];

    // Remember the previous level of the gated clock.
    always_ff @(posedge clk) begin
        if (!rst_n) gs_prev <= 1'b1;
        else        gs_prev <= gs_now;
    end

    assign fall_ev = gs_prev & ~gs_now;
    assign rise_ev = ~gs_prev & gs_now & ~cs_s;
endmodule

// File: rtl/adc_emu_ctrl.sv
// Counts rising edges and captures the channel request from the control word.
// Only the select and reserved bits are stored; the rest are discarded. The
// request is committed at the last control bit, so an aborted frame leaves it.
module adc_emu_ctrl
    import adc_emu_pkg::*;
#(
    parameter int FRAME_CLKS = 16,
    parameter int CTRL_W     = 8,
    parameter int SEL_BIT    = 3,
    parameter int ERR_BIT    = 4,
    localparam int CW        = $clog2(FRAME_CLKS + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_s,
    input  logic      rise_ev,
    input  logic      din_s,
    output chan_req_t pend,
    output logic      commit
);
    localparam int SEL_RISE = CTRL_W - SEL_BIT;
    localparam int ERR_RISE = CTRL_W - ERR_BIT;

    logic [CW-1:0] rcnt, rnext;
    logic          sel_tmp, err_tmp;

    assign rnext  = (rcnt == CW'(FRAME_CLKS)) ? CW'(1) : rcnt + CW'(1);
    assign commit = rise_ev && (rnext == CW'(CTRL_W));

    // Rising-edge counter, cleared while deselected and wrapped each frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) rcnt <= '0;
        else if (rise_ev)   rcnt <= rnext;
    end

    // Pick the select and reserved bits off the line as they pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_tmp <= 1'b0;
            err_tmp <= 1'b0;
        end else if (rise_ev) begin
            if (rnext == CW'(SEL_RISE)) sel_tmp <= din_s;
            if (rnext == CW'(ERR_RISE)) err_tmp <= din_s;
        end
    end

    // Commit the request for the next conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= '{sel: 1'b0, bad: 1'b0};
        else if (commit) pend <= '{sel: sel_tmp, bad: err_tmp};
    end
endmodule

// File: rtl/adc_emu_conv.sv
// Counts falling edges, holds the conversion value and drives the result bit.
// The value is taken at the hold edge from the channel pending at that time.
// The output bit changes one clk after each internal falling edge.
module adc_emu_conv
    import adc_emu_pkg::*;
#(
    parameter int DATA_W                   = 8,
    parameter int FRAME_CLKS               = 16,
    parameter int HOLD_EDGE                = 4,
    parameter int DATA_START               = 5,
    parameter logic [DATA_W-1:0] BAD_PATTERN = 'hA5,
    localparam int CW                      = $clog2(FRAME_CLKS + 1),
    localparam int DATA_END                = DATA_START + DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              fall_ev,
    input  chan_req_t         pend,
    input  logic [DATA_W-1:0] ch0_sample,
    input  logic [DATA_W-1:0] ch1_sample,
    output logic [CW-1:0]     fcnt,
    output logic              dout_bit,
    output logic              dout_oe
);
    logic [CW-1:0]     fnext, off;
    logic [DATA_W-1:0] held, src;
    logic              held_bad, in_data, nxt_bit;

    assign fnext   = (fcnt == CW'(FRAME_CLKS)) ? CW'(1) : fcnt + CW'(1);
    assign in_data = (fnext >= CW'(DATA_START)) && (fnext <= CW'(DATA_END));
    assign off     = fnext - CW'(DATA_START);
    assign src     = held_bad ? BAD_PATTERN : held;

    // Select the bit for the clock that the coming edge opens, MSB first.
    always_comb begin
        nxt_bit = 1'b0;
        for (int i = 0; i < DATA_W; i++)
            if (off == CW'(i)) nxt_bit = src[DATA_W-1-i];
    end

    // Falling-edge counter, cleared while deselected and wrapped each frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) fcnt <= '0;
        else if (fall_ev)   fcnt <= fnext;
    end

    // Capture the conversion value at the hold edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held     <= '0;
            held_bad <= 1'b0;
        end else if (fall_ev && !cs_s && fnext == CW'(HOLD_EDGE)) begin
            held     <= pend.sel ? ch1_sample : ch0_sample;
            held_bad <= pend.bad;
        end
    end

    // Drive the serial result on falling edges, zero outside the data clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) dout_bit <= 1'b0;
        else if (fall_ev)   dout_bit <= in_data & nxt_bit;
    end

    // Output enable follows chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) dout_oe <= 1'b0;
        else        dout_oe <= ~cs_s;
    end
endmodule

// File: rtl/adc_serial_emu.sv
// Top of the two-channel serial ADC device emulator.
// Assumes all link inputs are slow relative to clk (at least four clk periods
// per sclk phase). Drives dout to high-impedance while deselected.
module adc_serial_emu
    import adc_emu_pkg::*;
#(
    parameter int DATA_W                     = 8,
    parameter int FRAME_CLKS                 = 16,
    parameter int CTRL_W                     = 8,
    parameter int HOLD_EDGE                  = 4,
    parameter int DATA_START                 = 5,
    parameter int SEL_BIT                    = 3,
    parameter int ERR_BIT                    = 4,
    parameter int SYNC_STAGES                = 2,
    parameter logic [DATA_W-1:0] BAD_PATTERN = 'hA5,
    localparam int CW                        = $clog2(FRAME_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [DATA_W-1:0] ch0_sample,
    input  logic [DATA_W-1:0] ch1_sample,
    output logic              dout,
    output logic              dout_oe,
    output logic              addr_err
);
    logic      cs_s, din_s, fall_ev, rise_ev, commit, dout_bit;
    chan_req_t pend;
    logic [CW-1:0] fcnt;

    adc_emu_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cs_s(cs_s), .din_s(din_s), .fall_ev(fall_ev), .rise_ev(rise_ev)
    );

    adc_emu_ctrl #(
        .FRAME_CLKS(FRAME_CLKS), .CTRL_W(CTRL_W),
        .SEL_BIT(SEL_BIT), .ERR_BIT(ERR_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rise_ev(rise_ev),
        .din_s(din_s), .pend(pend), .commit(commit)
    );

    adc_emu_conv #(
        .DATA_W(DATA_W), .FRAME_CLKS(FRAME_CLKS), .HOLD_EDGE(HOLD_EDGE),
        .DATA_START(DATA_START), .BAD_PATTERN(BAD_PATTERN)
    ) u_conv (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .fall_ev(fall_ev),
        .pend(pend), .ch0_sample(ch0_sample), .ch1_sample(ch1_sample),
        .fcnt(fcnt), .dout_bit(dout_bit), .dout_oe(dout_oe)
    );

    assign dout     = dout_oe ? dout_bit : 1'bz;
    assign addr_err = pend.bad;
endmodule

// File: rtl/adc_serial_emu_chk.sv
// Protocol properties of the emulator, attached to its top by bind.
module adc_serial_emu_chk #(
    parameter int FRAME_CLKS = 16,
    parameter int DATA_START = 5,
    parameter int DATA_W     = 8,
    localparam int CW        = $clog2(FRAME_CLKS + 1),
    localparam int DATA_END  = DATA_START + DATA_W - 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_s,
    input logic          fall_ev,
    input logic          commit,
    input logic [CW-1:0] fcnt,
    input logic          dout_bit,
    input logic          dout_oe,
    input logic          addr_err
);
    p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !dout_oe);

    p_zero_slots_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && fcnt != '0 && (fcnt < CW'(DATA_START) || fcnt > CW'(DATA_END)))
        |-> !dout_bit);

    p_dout_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_ev && !cs_s) |=> $stable(dout_bit));

    p_frame_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev && !cs_s && fcnt == CW'(FRAME_CLKS)) |=> fcnt == CW'(1));

    p_err_at_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(addr_err));

    p_deselect_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> fcnt == '0);
endmodule

bind adc_serial_emu adc_serial_emu_chk #(
    .FRAME_CLKS(FRAME_CLKS), .DATA_START(DATA_START), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .fall_ev(fall_ev),
    .commit(commit), .fcnt(fcnt), .dout_bit(dout_bit),
    .dout_oe(dout_oe), .addr_err(addr_err)
);

// File: tb/adc_serial_emu_test.sv
module adc_serial_emu_test;
    localparam int PERIOD = 10;
    localparam int HALF   = 8;    // clk cycles per sclk phase
    localparam int NV     = 7;

    // Columns: control word, idle-low flag, ch0, ch1, mutate-after-hold flag
    localparam logic [7:0] V_CTRL [NV] = '{8'h00, 8'h08, 8'h28, 8'hC7, 8'h10, 8'h00, 8'h08};
    localparam bit         V_LOW  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [7:0] V_CH0  [NV] = '{8'h3C, 8'h81, 8'h11, 8'h5A, 8'hFF, 8'h22, 8'h01};
    localparam logic [7:0] V_CH1  [NV] = '{8'hC3, 8'h7E, 8'hF0, 8'h00, 8'h01, 8'h33, 8'h80};
    localparam bit         V_MUT  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam string      V_REQ  [NV] = '{"R7", "R2", "R3", "R6", "R4", "R8", "R5"};

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic [7:0] ch0_sample = '0, ch1_sample = '0;
    logic dout, dout_oe, addr_err;
    int checks = 0, failures = 0;
    bit m_sel = 1'b0, m_bad = 1'b0;   // bench model of the pending request

    adc_serial_emu uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .ch0_sample(ch0_sample), .ch1_sample(ch1_sample),
        .dout(dout), .dout_oe(dout_oe), .addr_err(addr_err)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_word(input logic [7:0] c0, input logic [7:0] c1);
        logic [7:0] d;
        d = m_bad ? 8'hA5 : (m_sel ? c1 : c0);
        return {4'b0, d, 4'b0};
    endfunction

    // Runs nfr frames under one chip-select window; bits collects dout MSB-first per clock.
    task automatic run_frames(input logic [7:0] c0, input logic [7:0] c1, input bit idle_low,
                              input int nfr, input int stop_after, input bit mutate,
                              output logic [31:0] bits, output bit oe_ok);
        bits  = '0;
        oe_ok = 1'b1;
        sclk  = idle_low ? 1'b0 : 1'b1;
        tick(HALF);
        din  = c0[7];
        cs_n = 1'b0;
        tick(HALF);
        for (int k = 1; k <= 16 * nfr; k++) begin
            int pos;
            logic [7:0] cw;
            if (k > stop_after) break;
            pos = (k - 1) % 16;
            cw  = (k <= 16) ? c0 : c1;
            if (k > 1 || !idle_low) begin
                sclk = 1'b0;
                din  = (pos < 8) ? cw[7 - pos] : 1'b0;
                tick(HALF);
            end
            if (mutate && k == 6) begin
                ch0_sample = ~ch0_sample;
                ch1_sample = ~ch1_sample;
            end
            bits = {bits[30:0], dout};
            if (dout_oe !== 1'b1) oe_ok = 1'b0;
            sclk = 1'b1;
            tick(HALF);
        end
        cs_n = 1'b1;
        din  = 1'b0;
        tick(HALF);
        sclk = 1'b0;
        tick(HALF);
    endtask

    initial begin
        #(PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] bits;
        bit oe_ok;
        logic [15:0] exp;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        // Reset state (R1, R8)
        check(dout_oe === 1'b0 && dout === 1'bz, "R1", {30'b0, dout_oe, dout}, 32'h0);
        check(addr_err === 1'b0, "R8", {31'b0, addr_err}, 32'h0);

        // Table-driven frames
        for (int v = 0; v < NV; v++) begin
            ch0_sample = V_CH0[v];
            ch1_sample = V_CH1[v];
            exp = expect_word(V_CH0[v], V_CH1[v]);
            run_frames(V_CTRL[v], 8'h00, V_LOW[v], 1, 16, V_MUT[v], bits, oe_ok);
            check(bits[15:0] === exp, V_REQ[v], {16'b0, bits[15:0]}, {16'b0, exp});
            check(oe_ok, "R1", {31'b0, oe_ok}, 32'h1);
            m_sel = V_CTRL[v][3];
            m_bad = V_CTRL[v][4];
            check(addr_err === m_bad, "R8", {31'b0, addr_err}, {31'b0, m_bad});
            check(dout_oe === 1'b0 && dout === 1'bz, "R1", {30'b0, dout_oe, dout}, 32'h0);
        end

        // R10: abort after five rising edges keeps the pending channel (second channel)
        ch0_sample = 8'h44;
        ch1_sample = 8'h99;
        run_frames(8'h10, 8'h00, 1'b0, 1, 5, 1'b0, bits, oe_ok);
        check(addr_err === 1'b0, "R10", {31'b0, addr_err}, 32'h0);
        exp = expect_word(8'h44, 8'h99);
        run_frames(8'h00, 8'h00, 1'b0, 1, 16, 1'b0, bits, oe_ok);
        check(bits[15:0] === exp && exp == 16'h0990, "R10", {16'b0, bits[15:0]}, {16'b0, exp});
        m_sel = 1'b0;
        m_bad = 1'b0;

        // R9: two frames under one chip select, each with its own control word
        run_frames(8'h08, 8'h00, 1'b1, 2, 32, 1'b0, bits, oe_ok);
        check(bits[31:16] === 16'h0440, "R9", {16'b0, bits[31:16]}, 32'h0440);
        check(bits[15:0] === 16'h0990, "R9", {16'b0, bits[15:0]}, 32'h0990);
        check(oe_ok, "R1", {31'b0, oe_ok}, 32'h1);
        run_frames(8'h00, 8'h00, 1'b0, 1, 16, 1'b0, bits, oe_ok);
        check(bits[15:0] === 16'h0440, "R9", {16'b0, bits[15:0]}, 32'h0440);

        // R7: a reset in the middle of operation restores the first channel
        run_frames(8'h08, 8'h00, 1'b0, 1, 16, 1'b0, bits, oe_ok);
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        run_frames(8'h00, 8'h00, 1'b1, 1, 16, 1'b0, bits, oe_ok);
        check(bits[15:0] === 16'h0440, "R7", {16'b0, bits[15:0]}, 32'h0440);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule